// File: doc/BRIEF.md
# Two-Processor Doorbell Mailbox Controller

The block lets two processors signal each other through per-channel doorbells. Each processor owns a bank of four registers. It raises an "occupied" flag on one of its channels to tell the peer that a message is waiting. The peer gets a receive interrupt and acknowledges by clearing that flag. The sender then gets a transmit interrupt, which means the channel is free again. Both interrupt kinds, on both processors, are gated per channel by mask bits and per processor by enable bits.

Two register ports of 32 bits, one per processor bus, reach the whole register map. A write strobe qualifies a write, and a read returns its data in the same cycle. The bank that an access addresses defines the processor acting: writing the set/clear register of bank p acts as processor p. The channel count is a parameter from 1 to 16, and a shared configuration word reports it.

Top module: `mbox_doorbell_ctrl`

## Requirements
- R1: After reset, both enable words read 0 and all occupied flags read 0. Every mask bit of a configured channel reads 1, which is 0x000F000F for 4 channels. All four interrupt outputs are low.
- R2: Bank p is at byte offset 0x10*p and holds its registers at these offsets: enable at +0x0, mask at +0x4, set/clear at +0x8, status at +0xC. A read of any other address reads 0, and so does a read of an address with bits 1:0 not zero, except 0x3F0 and 0x3F4.
- R3: In the enable register, bit 0 enables the receive interrupt and bit 16 enables the transmit interrupt. All other bits read 0.
- R4: Writing the set/clear register of bank p with bit 16+n at 1 sets processor p's occupied flag n, which then reads as bit n of bank p's status register. Bits written as 0 change nothing, and the set/clear register always reads 0.
- R5: Writing the set/clear register of bank p with bit n at 1 clears the other processor's occupied flag n.
- R6: When one port sets a flag and the other port clears the same flag in the same cycle, the flag ends set.
- R7: irq_rx[p] is high exactly when receive is enabled for p and, for some n, the peer's flag n is 1 while p's mask bit n is 0. The output is registered, so it follows a register change one clock edge later.
- R8: irq_tx[p] is high exactly when transmit is enabled for p and, for some configured n, p's own flag n is 0 while p's mask bit 16+n is 0. The output is registered in the same way as R7.
- R9: Writes to a status register are ignored.
- R10: Offset 0x3F0 reads the channel count in bits 7:0. Offset 0x3F4 reads the major revision in bits 7:4 and the minor revision in bits 3:0. All other bits of both words read 0.
- R11: Mask and flag bits for channels at or above the channel count read 0, and writes to them have no effect.
- R12: When both ports write the same enable or mask register in the same cycle, port 1's value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| p0_addr | input | 10 | Port 0 byte address |
| p0_wr | input | 1 | Port 0 write strobe |
| p0_wdata | input | 32 | Port 0 write data |
| p0_rdata | output | 32 | Port 0 read data, combinational from p0_addr |
| p1_addr | input | 10 | Port 1 byte address |
| p1_wr | input | 1 | Port 1 write strobe |
| p1_wdata | input | 32 | Port 1 write data |
| p1_rdata | output | 32 | Port 1 read data, combinational from p1_addr |
| irq_rx | output | 2 | Per-processor receive (peer channel occupied) interrupt |
| irq_tx | output | 2 | Per-processor transmit (channel free) interrupt |

## Verification
Two functions can fall in the same cycle: a processor raising its own flag through its set/clear register, and the peer acknowledging that same flag through the peer's set/clear register. The bench drives both ports in one cycle with a set on one and a clear on the other, in both port orientations, with the flag starting both cleared and set. It judges the outcome by reading the status register: the flag must end set. The interrupt sweep uses this same collision on every step, clearing all of a processor's flags while setting a pattern, so any wrong merge order shows up as a wrong interrupt over the whole sweep.

// File: rtl/mbox_pkg.sv
// Package: shared constants, register selector type and address decoder
// for the doorbell mailbox. Assumes a fixed 10-bit byte address space.
package mbox_pkg;

    localparam int ADDR_W   = 10;
    localparam int MAX_CH   = 16;
    localparam int NPROC    = 2;
    localparam logic [ADDR_W-3:0] CFG_WORD = 8'hFC;  // byte 0x3F0
    localparam logic [ADDR_W-3:0] VER_WORD = 8'hFD;  // byte 0x3F4

    typedef enum logic [1:0] {
        REG_ENABLE = 2'd0,
        REG_MASK   = 2'd1,
        REG_SETCLR = 2'd2,
        REG_STATUS = 2'd3
    } bank_reg_e;

    typedef struct packed {
        logic      hit;   // address falls in a processor bank
        logic      bank;  // which processor bank
        bank_reg_e sel;   // register within the bank
        logic      cfg;   // shared channel-count word
        logic      ver;   // shared revision word
    } addr_dec_t;

    // Decode one byte address into bank, register and shared-word hits.
    function automatic addr_dec_t decode_addr(input logic [ADDR_W-1:0] a);
        addr_dec_t d;
        d      = '0;
        d.cfg  = (a[ADDR_W-1:2] == CFG_WORD) && (a[1:0] == 2'b00);
        d.ver  = (a[ADDR_W-1:2] == VER_WORD) && (a[1:0] == 2'b00);
        if ((a[ADDR_W-1:5] == '0) && (a[1:0] == 2'b00)) begin
            d.hit  = 1'b1;
            d.bank = a[4];
            d.sel  = bank_reg_e'(a[3:2]);
        end
        return d;
    endfunction

endpackage

// File: rtl/mbox_bank_regs.sv
// Module: one processor's enable bits and channel masks.
// Assumes the write strobes are already decoded for this bank; when both
// ports hit the same register in one cycle, port 1 is applied last and wins.
module mbox_bank_regs #(
    parameter int NUM_CH = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [1:0]                  wr_enable,
    input  logic [1:0]                  wr_mask,
    input  logic [1:0][31:0]            wdata,
    output logic                        rx_en,
    output logic                        tx_en,
    output logic [NUM_CH-1:0]           rx_mask,
    output logic [NUM_CH-1:0]           tx_mask
);

    logic unused_wdata;
    assign unused_wdata = ^wdata;

    // Store enables and masks; masks come up fully set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_en   <= 1'b0;
            tx_en   <= 1'b0;
            rx_mask <= '1;
            tx_mask <= '1;
        end else begin
            for (int i = 0; i < 2; i++) begin
                if (wr_enable[i]) begin
                    rx_en <= wdata[i][0];
                    tx_en <= wdata[i][16];
                end
                if (wr_mask[i]) begin
                    rx_mask <= wdata[i][NUM_CH-1:0];
                    tx_mask <= wdata[i][16 +: NUM_CH];
                end
            end
        end
    end

endmodule

// File: rtl/mbox_occ_flags.sv
// Module: occupied flags of both processors.
// A set/clear write to bank p sets p's flags from the upper half and clears
// the other processor's flags from the lower half. Clears from both ports are
// merged, sets from both ports are merged, and a set beats a clear.
module mbox_occ_flags #(
    parameter int NUM_CH = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [1:0]                  wr_setclr,
    input  logic [1:0]                  wr_bank,
    input  logic [1:0][31:0]            wdata,
    output logic [1:0][NUM_CH-1:0]      occ
);

    logic [1:0][NUM_CH-1:0] set_v;
    logic [1:0][NUM_CH-1:0] clr_v;
    logic                   unused_wdata;

    assign unused_wdata = ^wdata;

    // Gather set and clear requests per processor from both ports.
    always_comb begin
        set_v = '0;
        clr_v = '0;
        for (int i = 0; i < 2; i++) begin
            if (wr_setclr[i]) begin
                set_v[wr_bank[i]]         = set_v[wr_bank[i]] | wdata[i][16 +: NUM_CH];
                clr_v[wr_bank[i] ^ 1'b1]  = clr_v[wr_bank[i] ^ 1'b1] | wdata[i][NUM_CH-1:0];
            end
        end
    end

    for (genvar p = 0; p < 2; p++) begin : g_proc
        // Update one processor's flags, set taking priority.
        always_ff @(posedge clk) begin
            if (!rst_n) occ[p] <= '0;
            else        occ[p] <= (occ[p] & ~clr_v[p]) | set_v[p];
        end
    end

endmodule

// File: rtl/mbox_irq_gen.sv
// Module: registered receive and transmit interrupts for one processor.
// Assumes the peer's and own flags plus this processor's masks as inputs.
module mbox_irq_gen #(
    parameter int NUM_CH = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_en,
    input  logic               tx_en,
    input  logic [NUM_CH-1:0]  rx_mask,
    input  logic [NUM_CH-1:0]  tx_mask,
    input  logic [NUM_CH-1:0]  peer_occ,
    input  logic [NUM_CH-1:0]  own_occ,
    output logic               irq_rx,
    output logic               irq_tx
);

    logic rx_pending;
    logic tx_pending;

    // Find any unmasked occupied peer channel and any unmasked free own channel.
    always_comb begin
        rx_pending = |(peer_occ & ~rx_mask);
        tx_pending = |(~own_occ & ~tx_mask);
    end

    // Register the gated interrupt levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_rx <= 1'b0;
            irq_tx <= 1'b0;
        end else begin
            irq_rx <= rx_en & rx_pending;
            irq_tx <= tx_en & tx_pending;
        end
    end

endmodule

// File: rtl/mbox_read_mux.sv
// Module: read data selection for one port. Purely combinational; reads have
// no side effects. Unconfigured channel bits are zero-extended away.
module mbox_read_mux #(
    parameter int NUM_CH    = 16,
    parameter int VER_MAJOR = 1,
    parameter int VER_MINOR = 2
) (
    input  mbox_pkg::addr_dec_t         dec,
    input  logic [1:0]                  rx_en,
    input  logic [1:0]                  tx_en,
    input  logic [1:0][NUM_CH-1:0]      rx_mask,
    input  logic [1:0][NUM_CH-1:0]      tx_mask,
    input  logic [1:0][NUM_CH-1:0]      occ,
    output logic [31:0]                 rdata
);
    import mbox_pkg::*;

    // Select the addressed word.
    always_comb begin
        rdata = '0;
        if (dec.cfg) begin
            rdata[7:0] = 8'(NUM_CH);
        end else if (dec.ver) begin
            rdata[7:0] = {4'(VER_MAJOR), 4'(VER_MINOR)};
        end else if (dec.hit) begin
            case (dec.sel)
                REG_ENABLE: begin
                    rdata[0]  = rx_en[dec.bank];
                    rdata[16] = tx_en[dec.bank];
                end
                REG_MASK:   rdata = {16'(tx_mask[dec.bank]), 16'(rx_mask[dec.bank])};
                REG_STATUS: rdata = {16'h0, 16'(occ[dec.bank])};
                default:    rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/mbox_doorbell_ctrl.sv
// Module: top of the two-processor doorbell mailbox.
// Two register ports each reach the whole map; the addressed bank names the
// acting processor. Assumes 1 <= NUM_CH <= 16.
module mbox_doorbell_ctrl #(
    parameter int NUM_CH    = 16,
    parameter int VER_MAJOR = 1,
    parameter int VER_MINOR = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [9:0]  p0_addr,
    input  logic        p0_wr,
    input  logic [31:0] p0_wdata,
    output logic [31:0] p0_rdata,
    input  logic [9:0]  p1_addr,
    input  logic        p1_wr,
    input  logic [31:0] p1_wdata,
    output logic [31:0] p1_rdata,
    output logic [1:0]  irq_rx,
    output logic [1:0]  irq_tx
);
    import mbox_pkg::*;

    logic [1:0][ADDR_W-1:0]   addr_a;
    logic [1:0]               wr_a;
    logic [1:0][31:0]         wdata_a;
    logic [1:0][31:0]         rdata_a;
    addr_dec_t                dec [2];
    logic [1:0]               wr_hit;
    logic [1:0]               wr_scr;
    logic [1:0]               scr_bank;
    logic [1:0][1:0]          wr_enable;   // [bank][port]
    logic [1:0][1:0]          wr_mask;     // [bank][port]
    logic [1:0]               rx_en_q;
    logic [1:0]               tx_en_q;
    logic [1:0][NUM_CH-1:0]   rx_mask_q;
    logic [1:0][NUM_CH-1:0]   tx_mask_q;
    logic [1:0][NUM_CH-1:0]   occ_q;

    assign addr_a   = {p1_addr, p0_addr};
    assign wr_a     = {p1_wr, p0_wr};
    assign wdata_a  = {p1_wdata, p0_wdata};
    assign p0_rdata = rdata_a[0];
    assign p1_rdata = rdata_a[1];

    for (genvar i = 0; i < 2; i++) begin : g_port
        assign dec[i]      = decode_addr(addr_a[i]);
        assign wr_hit[i]   = wr_a[i] & dec[i].hit;
        assign wr_scr[i]   = wr_hit[i] && (dec[i].sel == REG_SETCLR);
        assign scr_bank[i] = dec[i].bank;

        mbox_read_mux #(
            .NUM_CH    (NUM_CH),
            .VER_MAJOR (VER_MAJOR),
            .VER_MINOR (VER_MINOR)
        ) u_rd (
            .dec     (dec[i]),
            .rx_en   (rx_en_q),
            .tx_en   (tx_en_q),
            .rx_mask (rx_mask_q),
            .tx_mask (tx_mask_q),
            .occ     (occ_q),
            .rdata   (rdata_a[i])
        );
    end

    // Route decoded enable and mask writes to the addressed bank.
    always_comb begin
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < 2; i++) begin
                wr_enable[p][i] = wr_hit[i] && (dec[i].bank == 1'(p)) && (dec[i].sel == REG_ENABLE);
                wr_mask[p][i]   = wr_hit[i] && (dec[i].bank == 1'(p)) && (dec[i].sel == REG_MASK);
            end
        end
    end

    for (genvar p = 0; p < 2; p++) begin : g_bank
        mbox_bank_regs #(.NUM_CH(NUM_CH)) u_regs (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_enable (wr_enable[p]),
            .wr_mask   (wr_mask[p]),
            .wdata     (wdata_a),
            .rx_en     (rx_en_q[p]),
            .tx_en     (tx_en_q[p]),
            .rx_mask   (rx_mask_q[p]),
            .tx_mask   (tx_mask_q[p])
        );

        mbox_irq_gen #(.NUM_CH(NUM_CH)) u_irq (
            .clk      (clk),
            .rst_n    (rst_n),
            .rx_en    (rx_en_q[p]),
            .tx_en    (tx_en_q[p]),
            .rx_mask  (rx_mask_q[p]),
            .tx_mask  (tx_mask_q[p]),
            .peer_occ (occ_q[1-p]),
            .own_occ  (occ_q[p]),
            .irq_rx   (irq_rx[p]),
            .irq_tx   (irq_tx[p])
        );
    end

    mbox_occ_flags #(.NUM_CH(NUM_CH)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_setclr (wr_scr),
        .wr_bank   (scr_bank),
        .wdata     (wdata_a),
        .occ       (occ_q)
    );

endmodule

// File: rtl/mbox_doorbell_chk.sv
// Module: property checker for the doorbell mailbox, bound to the top.
// Observes ports and the stored flags and enables.
module mbox_doorbell_chk #(
    parameter int NUM_CH = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [9:0]             p0_addr,
    input  logic                   p0_wr,
    input  logic [31:0]            p0_wdata,
    input  logic [31:0]            p0_rdata,
    input  logic [9:0]             p1_addr,
    input  logic                   p1_wr,
    input  logic [31:0]            p1_wdata,
    input  logic [31:0]            p1_rdata,
    input  logic [1:0]             irq_rx,
    input  logic [1:0]             irq_tx,
    input  logic [1:0][NUM_CH-1:0] occ,
    input  logic [1:0]             rx_en,
    input  logic [1:0]             tx_en
);

    // R6
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_wr && p0_addr == 10'h008 && p0_wdata[16] && p1_wr && p1_addr == 10'h018 && p1_wdata[0])
        |=> occ[0][0]);

    // R9
    status_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_wr && p0_addr == 10'h00C && !p1_wr) |=> $stable(occ));

    // R7
    rx_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx[0] |-> $past(rx_en[0] && (|occ[1])));

    // R8
    tx_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx[1] |-> $past(tx_en[1] && !(&occ[1])));

    // R10
    chan_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_addr == 10'h3F0) |-> (p0_rdata == 32'(NUM_CH)));

    // R4
    setclr_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p1_addr[9:5] == 5'd0 && p1_addr[3:0] == 4'h8) |-> (p1_rdata == 32'h0));

endmodule

bind mbox_doorbell_ctrl mbox_doorbell_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .p0_addr  (p0_addr),
    .p0_wr    (p0_wr),
    .p0_wdata (p0_wdata),
    .p0_rdata (p0_rdata),
    .p1_addr  (p1_addr),
    .p1_wr    (p1_wr),
    .p1_wdata (p1_wdata),
    .p1_rdata (p1_rdata),
    .irq_rx   (irq_rx),
    .irq_tx   (irq_tx),
    .occ      (occ_q),
    .rx_en    (rx_en_q),
    .tx_en    (tx_en_q)
);

// File: tb/tb_mbox_doorbell_ctrl.sv
// Bench: near-exhaustive sweeps over a 4-channel configuration with a
// bench-side register model built from the requirements.
module tb_mbox_doorbell_ctrl;

    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [9:0]  a0, a1;
    logic        w0, w1;
    logic [31:0] d0, d1;
    logic [31:0] r0, r1;
    logic [1:0]  irq_rx, irq_tx;

    int checks = 0;
    int errors = 0;

    logic [1:0]       m_rxen, m_txen;
    logic [NCH-1:0]   m_rxm [2];
    logic [NCH-1:0]   m_txm [2];
    logic [NCH-1:0]   m_occ [2];

    always #2 clk = ~clk;

    mbox_doorbell_ctrl #(.NUM_CH(NCH)) dut (
        .clk(clk), .rst_n(rst_n),
        .p0_addr(a0), .p0_wr(w0), .p0_wdata(d0), .p0_rdata(r0),
        .p1_addr(a1), .p1_wr(w1), .p1_wdata(d1), .p1_rdata(r1),
        .irq_rx(irq_rx), .irq_tx(irq_tx)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Model reset per R1.
    task automatic model_reset();
        m_rxen = '0; m_txen = '0;
        for (int b = 0; b < 2; b++) begin
            m_rxm[b] = '1; m_txm[b] = '1; m_occ[b] = '0;
        end
    endtask

    // Model one cycle of writes from both ports per R2-R6, R9, R11, R12.
    task automatic model_write(input logic we0, input logic [9:0] ad0, input logic [31:0] dt0,
                               input logic we1, input logic [9:0] ad1, input logic [31:0] dt1);
        logic [NCH-1:0] setv [2];
        logic [NCH-1:0] clrv [2];
        logic [9:0]     ad;
        logic [31:0]    dt;
        setv[0] = '0; setv[1] = '0; clrv[0] = '0; clrv[1] = '0;
        for (int i = 0; i < 2; i++) begin
            ad = (i == 0) ? ad0 : ad1;
            dt = (i == 0) ? dt0 : dt1;
            if (((i == 0) ? we0 : we1) && ad < 10'h20 && ad[1:0] == 2'b00) begin
                case (ad[3:2])
                    2'd0: begin m_rxen[ad[4]] = dt[0]; m_txen[ad[4]] = dt[16]; end
                    2'd1: begin m_rxm[ad[4]] = dt[NCH-1:0]; m_txm[ad[4]] = dt[16 +: NCH]; end
                    2'd2: begin
                        setv[ad[4]]  = setv[ad[4]]  | dt[16 +: NCH];
                        clrv[!ad[4]] = clrv[!ad[4]] | dt[NCH-1:0];
                    end
                    default: ;
                endcase
            end
        end
        for (int b = 0; b < 2; b++) m_occ[b] = (m_occ[b] & ~clrv[b]) | setv[b];
    endtask

    // Drive one cycle of writes on both ports; returns at the following negedge.
    task automatic wr2(input logic we0, input logic [9:0] ad0, input logic [31:0] dt0,
                       input logic we1, input logic [9:0] ad1, input logic [31:0] dt1);
        @(negedge clk);
        w0 = we0; a0 = ad0; d0 = dt0;
        w1 = we1; a1 = ad1; d1 = dt1;
        @(posedge clk);
        model_write(we0, ad0, dt0, we1, ad1, dt1);
        @(negedge clk);
        w0 = 1'b0; w1 = 1'b0;
    endtask

    task automatic wr(input logic [9:0] ad, input logic [31:0] dt);
        wr2(1'b1, ad, dt, 1'b0, 10'h0, 32'h0);
    endtask

    // Read through one port between edges and compare.
    task automatic rd_chk(input int port, input logic [9:0] ad, input logic [31:0] exp, input string tag);
        logic [31:0] act;
        if (port == 0) a0 = ad; else a1 = ad;
        #1;
        act = (port == 0) ? r0 : r1;
        check(act === exp, tag, act, exp);
    endtask

    // Compare every bank register against the model.
    task automatic chk_regs(input string tag);
        for (int b = 0; b < 2; b++) begin
            rd_chk(b, 10'(b*16 + 0), {15'h0, m_txen[b], 15'h0, m_rxen[b]}, {tag, " enable"});
            rd_chk(1-b, 10'(b*16 + 4), {16'(m_txm[b]), 16'(m_rxm[b])}, {tag, " mask"});
            rd_chk(b, 10'(b*16 + 8), 32'h0, {tag, " setclr R4"});
            rd_chk(1-b, 10'(b*16 + 12), {16'h0, 16'(m_occ[b])}, {tag, " status"});
        end
    endtask

    // Let one more edge pass, then compare interrupts with R7/R8 formulas.
    task automatic chk_irq(input string tag);
        logic [1:0] erx, etx;
        @(negedge clk);
        for (int p = 0; p < 2; p++) begin
            erx[p] = m_rxen[p] & |(m_occ[1-p] & ~m_rxm[p]);
            etx[p] = m_txen[p] & |(~m_occ[p] & ~m_txm[p]);
        end
        check(irq_rx === erx, {tag, " irq_rx R7"}, 32'(irq_rx), 32'(erx));
        check(irq_tx === etx, {tag, " irq_tx R8"}, 32'(irq_tx), 32'(etx));
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        w0 = 0; w1 = 0; a0 = 0; a1 = 0; d0 = 0; d1 = 0;
        model_reset();
        repeat (3) @(negedge clk);
        check(irq_rx === 2'b00 && irq_tx === 2'b00, "R1 irq in reset", {irq_rx, irq_tx}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset contents
        rd_chk(0, 10'h004, 32'h000F000F, "R1 mask bank0");
        chk_regs("R1 reset");
        chk_irq("R1 reset");

        // R10 shared words, R2 unmapped and misaligned reads
        rd_chk(0, 10'h3F0, 32'd4, "R10 channel count p0");
        rd_chk(1, 10'h3F0, 32'd4, "R10 channel count p1");
        rd_chk(1, 10'h3F4, 32'h12, "R10 revision");
        rd_chk(0, 10'h020, 32'h0, "R2 unmapped 0x20");
        rd_chk(0, 10'h3F8, 32'h0, "R2 unmapped 0x3F8");
        rd_chk(1, 10'h005, 32'h0, "R2 misaligned mask");

        // R3 enable bits
        wr(10'h000, 32'hFFFF_FFFF);
        rd_chk(0, 10'h000, 32'h0001_0001, "R3 enable reads only bits 0,16");
        wr(10'h010, 32'h0001_0000);
        rd_chk(1, 10'h010, 32'h0001_0000, "R3 bank1 tx enable only");
        chk_regs("R3");

        // R11 upper channel bits ignored
        wr(10'h014, 32'hFFF5_FFFA);
        rd_chk(0, 10'h014, 32'h0005_000A, "R11 mask upper bits");
        wr(10'h008, 32'hFFF0_0000);
        rd_chk(0, 10'h00C, 32'h0, "R11 flag upper bits");
        chk_regs("R11");

        // R4/R5 per-channel set then peer clear, both processors
        for (int p = 0; p < 2; p++) begin
            for (int n = 0; n < NCH; n++) begin
                wr(10'(p*16 + 8), 32'h1 << (16 + n));
                rd_chk(p, 10'(p*16 + 12), 32'h1 << n, "R4 set flag");
                wr(10'(p*16 + 8), 32'h0);
                rd_chk(p, 10'(p*16 + 12), 32'h1 << n, "R4 zero write no effect");
                wr(10'((1-p)*16 + 8), 32'h1 << n);
                rd_chk(1-p, 10'(p*16 + 12), 32'h0, "R5 peer clear");
            end
        end

        // R9 status writes ignored
        wr(10'h008, 32'h000A_0000);
        wr(10'h00C, 32'hFFFF_FFFF);
        wr(10'h01C, 32'h0000_0000);
        rd_chk(0, 10'h00C, 32'h0000_000A, "R9 status write ignored");
        chk_regs("R9");

        // R6 same-cycle set and clear, both orientations, flag starting 0 and 1
        for (int n = 0; n < NCH; n++) begin
            for (int pre = 0; pre < 2; pre++) begin
                wr(10'h018, 32'hF);
                wr(10'h008, 32'(pre) << (16 + n));
                wr2(1'b1, 10'h008, 32'h1 << (16 + n), 1'b1, 10'h018, 32'h1 << n);
                rd_chk(0, 10'h00C, 32'h1 << n, "R6 set beats clear p0 set");
                wr(10'h008, 32'hF);
                wr(10'h018, 32'(pre) << (16 + n));
                wr2(1'b1, 10'h008, 32'h1 << n, 1'b1, 10'h018, 32'h1 << (16 + n));
                rd_chk(1, 10'h01C, 32'h1 << n, "R6 set beats clear p1 set");
            end
        end

        // R12 both ports to the same register
        wr2(1'b1, 10'h004, 32'h0003_0003, 1'b1, 10'h004, 32'h000C_0009);
        rd_chk(0, 10'h004, 32'h000C_0009, "R12 port1 wins mask");
        wr2(1'b1, 10'h010, 32'h0001_0001, 1'b1, 10'h010, 32'h0);
        rd_chk(1, 10'h010, 32'h0, "R12 port1 wins enable");
        chk_regs("R12");

        // R7/R8 exhaustive over flag pattern and mask for each sender
        wr2(1'b1, 10'h000, 32'h0001_0001, 1'b1, 10'h010, 32'h0001_0001);
        for (int p = 0; p < 2; p++) begin
            for (int f = 0; f < 16; f++) begin
                for (int m = 0; m < 16; m++) begin
                    wr2(1'b1, 10'((1-p)*16 + 8), 32'hF,
                        1'b1, 10'(p*16 + 8), 32'(f) << 16);
                    wr2(1'b1, 10'h004, {12'h0, 4'(m), 12'h0, 4'(m)},
                        1'b1, 10'h014, {12'h0, 4'(m), 12'h0, 4'(m)});
                    chk_irq("R7/R8 sweep");
                end
            end
        end

        // R7/R8 enable gating
        wr2(1'b1, 10'h004, 32'h0, 1'b1, 10'h014, 32'h0);
        wr2(1'b1, 10'h008, 32'h0003_0000, 1'b1, 10'h018, 32'h0);
        chk_irq("R7 enabled");
        wr2(1'b1, 10'h000, 32'h0, 1'b1, 10'h010, 32'h0);
        chk_irq("R8 disabled");

        // R7 registered timing: level drops one edge after the flag clears
        wr2(1'b1, 10'h000, 32'h1, 1'b1, 10'h010, 32'h1);
        @(negedge clk);
        check(irq_rx[1] === 1'b1, "R7 rx asserted", 32'(irq_rx), 32'h2);
        wr(10'h018, 32'hF);
        check(irq_rx[1] === 1'b1, "R7 still high before next edge", 32'(irq_rx), 32'h2);
        @(negedge clk);
        check(irq_rx[1] === 1'b0, "R7 dropped one edge later", 32'(irq_rx), 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule